// File: doc/BRIEF.md
# Bufferless Deflection Switch Allocator

This block is the per-cycle output allocator of a router in a two-dimensional mesh that holds no flits. In every cycle it receives up to four flits from the neighbouring routers and one candidate flit from the local core. Each flit carries an age stamp and a destination coordinate. The block gives each flit its own output port in that same cycle, and the chosen flits appear on the five registered output slots one clock later. A flit is never stored and never waits. When it cannot move toward its destination, it is sent out in some other direction, which is called deflection.

Flits are handled strictly in order of seniority: greater age first, and on equal age the lower input slot index first. Each flit in turn takes a free port that moves it closer to its destination. Horizontal movement is tried before vertical movement. A flit that has already arrived takes the single ejection port. Any flit that finds no productive port free is sent out on the lowest-numbered free link port. The local candidate is admitted only in a cycle in which at least one neighbour slot is empty. This keeps the number of flits that need a link port at or below four, so a port always exists for every admitted flit.

Top module: `dfl_switch_alloc`

## Requirements
- R1: Every admitted flit (each valid link slot, plus the local candidate when acknowledged) appears on exactly one output slot in the cycle after it is presented, with its age and destination unchanged. An output slot never carries a flit that was not admitted.
- R2: Output slots are registered, with a latency of one clock from input to output. While reset is asserted and right after it, every output valid bit is 0.
- R3: `inj_ack` is high in the same cycle exactly when `inj_req` is high and at least one of the four `lnk_vld` bits is 0. The local candidate occupies candidate index 4.
- R4: Flits are served in decreasing order of age, where a larger age value means older. Equal ages are served in increasing candidate index: 0..3 are the link slots and 4 is the local candidate.
- R5: When it is served, a flit takes a free port that reduces its distance to its destination if one is free.
- R6: When both a horizontal and a vertical port are productive and both are free, the flit takes the horizontal one. A destination x greater than the node's x is served by port 1 (east) and a smaller one by port 3 (west). A destination y greater than the node's y is served by port 0 (north) and a smaller one by port 2 (south).
- R7: A flit whose destination equals the node coordinate takes output port 4 (ejection) if that port is still free. At most one flit leaves through port 4 per cycle, and a later-served arrived flit is deflected.
- R8: A flit with no free productive port is deflected to the lowest-numbered free link port among 0..3.
- R9: A flit whose destination differs from the node coordinate never leaves through port 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| node_x | input | XW | X coordinate of this router |
| node_y | input | YW | Y coordinate of this router |
| lnk_vld | input | 4 | Valid bits of the four neighbour slots (0 N, 1 E, 2 S, 3 W) |
| lnk_age | input | 4*AW | Age stamp per neighbour slot |
| lnk_dx | input | 4*XW | Destination x per neighbour slot |
| lnk_dy | input | 4*YW | Destination y per neighbour slot |
| inj_req | input | 1 | Local core offers a flit |
| inj_age | input | AW | Age stamp of the offered flit |
| inj_dx | input | XW | Destination x of the offered flit |
| inj_dy | input | YW | Destination y of the offered flit |
| inj_ack | output | 1 | Offered flit admitted this cycle |
| out_vld | output | 5 | Valid bit per output port (0 N, 1 E, 2 S, 3 W, 4 eject) |
| out_age | output | 5*AW | Age stamp per output port |
| out_dx | output | 5*XW | Destination x per output port |
| out_dy | output | 5*YW | Destination y per output port |

## Verification
Ejection and deflection often fall in the same cycle. When two arrived flits compete, the younger one must be pushed onto a link port while the older one takes port 4. The bench provokes this with a directed case that presents two flits addressed to the node, and many random cycles add more of the same, because about a quarter of the destinations equal the node coordinate. Local admission and full-port contention also collide. The bench presents four valid link flits together with a request and judges the acknowledge in that cycle and the placement of all flits one cycle later, against a behavioural seniority model.

// File: rtl/dfl_pkg.sv
package dfl_pkg;
    localparam int NLINK = 4;
    localparam int NPORT = NLINK + 1;
    localparam int PW    = $clog2(NPORT);

    typedef logic [PW-1:0] port_idx_t;

    localparam port_idx_t PORT_N = 3'd0;
    localparam port_idx_t PORT_E = 3'd1;
    localparam port_idx_t PORT_S = 3'd2;
    localparam port_idx_t PORT_W = 3'd3;
    localparam port_idx_t PORT_L = 3'd4;
endpackage

// File: rtl/dfl_age_rank.sv
module dfl_age_rank #(
    parameter int N  = 5,
    parameter int AW = 6,
    localparam int RW = $clog2(N)
) (
    input  logic [N-1:0]         vld,
    input  logic [N-1:0][AW-1:0] age,
    output logic [N-1:0][RW-1:0] rank
);
    logic [RW-1:0] cnt;

    always_comb begin
        rank = '0;
        cnt  = '0;
        for (int i = 0; i < N; i++) begin
            cnt = '0;
            for (int j = 0; j < N; j++) begin
                if (j != i && vld[j]) begin
                    if ((age[j] > age[i]) || ((age[j] == age[i]) && (j < i))) begin
                        cnt = cnt + RW'(1);
                    end
                end
            end
            rank[i] = cnt;
        end
    end
endmodule

// File: rtl/dfl_route_pref.sv
module dfl_route_pref
    import dfl_pkg::*;
#(
    parameter int XW = 3,
    parameter int YW = 3
) (
    input  logic [XW-1:0] node_x,
    input  logic [YW-1:0] node_y,
    input  logic [XW-1:0] dst_x,
    input  logic [YW-1:0] dst_y,
    output logic          at_home,
    output logic          x_ok,
    output port_idx_t     x_port,
    output logic          y_ok,
    output port_idx_t     y_port
);
    always_comb begin
        x_ok    = (dst_x != node_x);
        y_ok    = (dst_y != node_y);
        x_port  = (dst_x > node_x) ? PORT_E : PORT_W;
        y_port  = (dst_y > node_y) ? PORT_N : PORT_S;
        at_home = !x_ok && !y_ok;
    end
endmodule

// File: rtl/dfl_port_assign.sv
module dfl_port_assign
    import dfl_pkg::*;
#(
    parameter int N = NPORT,
    localparam int RW = $clog2(N),
    localparam int SW = $clog2(N)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N-1:0]          vld,
    input  logic [N-1:0][RW-1:0]  rank,
    input  logic [N-1:0]          at_home,
    input  logic [N-1:0]          x_ok,
    input  port_idx_t [N-1:0]     x_port,
    input  logic [N-1:0]          y_ok,
    input  port_idx_t [N-1:0]     y_port,
    output logic [NPORT-1:0]      port_busy,
    output logic [NPORT-1:0][SW-1:0] port_src
);
    logic [NPORT-1:0]        free;
    logic [NPORT-1:0][N-1:0] gmat;
    logic                    took;
    port_idx_t               pick;

    always_comb begin
        free      = '1;
        port_busy = '0;
        port_src  = '0;
        gmat      = '0;
        took      = 1'b0;
        pick      = PORT_N;
        for (int r = 0; r < N; r++) begin
            for (int i = 0; i < N; i++) begin
                if (vld[i] && (rank[i] == RW'(r))) begin
                    took = 1'b0;
                    pick = PORT_N;
                    if (at_home[i] && free[PORT_L]) begin
                        pick = PORT_L;
                        took = 1'b1;
                    end else if (x_ok[i] && free[x_port[i]]) begin
                        pick = x_port[i];
                        took = 1'b1;
                    end else if (y_ok[i] && free[y_port[i]]) begin
                        pick = y_port[i];
                        took = 1'b1;
                    end
                    for (int p = 0; p < NLINK; p++) begin
                        if (!took && free[p]) begin
                            pick = PW'(p);
                            took = 1'b1;
                        end
                    end
                    if (took) begin
                        free[pick]    = 1'b0;
                        port_busy[pick] = 1'b1;
                        port_src[pick]  = SW'(i);
                        gmat[pick][i]   = 1'b1;
                    end
                end
            end
        end
    end

    generate
        for (genvar gi = 0; gi < N; gi++) begin : g_chk
            logic [NPORT-1:0] col;
            always_comb begin
                for (int p = 0; p < NPORT; p++) col[p] = gmat[p][gi];
            end

            AST_FLIT_PLACED: assert property (@(posedge clk) disable iff (!rst_n)
                vld[gi] |-> ($countones(col) == 1)) else $error("flit not placed once"); // R1
            AST_IDLE_UNPLACED: assert property (@(posedge clk) disable iff (!rst_n)
                !vld[gi] |-> (col == '0)) else $error("idle slot placed"); // R1
            AST_SENIOR_X: assert property (@(posedge clk) disable iff (!rst_n)
                (vld[gi] && rank[gi] == '0 && x_ok[gi]) |-> gmat[x_port[gi]][gi])
                else $error("senior flit lost x port"); // R6
            AST_SENIOR_Y: assert property (@(posedge clk) disable iff (!rst_n)
                (vld[gi] && rank[gi] == '0 && !x_ok[gi] && y_ok[gi]) |-> gmat[y_port[gi]][gi])
                else $error("senior flit lost y port"); // R5
            AST_SENIOR_EJECT: assert property (@(posedge clk) disable iff (!rst_n)
                (vld[gi] && rank[gi] == '0 && at_home[gi]) |-> gmat[PORT_L][gi])
                else $error("senior arrived flit not ejected"); // R7
            AST_EJECT_HOME_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
                gmat[PORT_L][gi] |-> at_home[gi]) else $error("foreign flit ejected"); // R9
        end
    endgenerate
endmodule

// File: rtl/dfl_switch_alloc.sv
module dfl_switch_alloc
    import dfl_pkg::*;
#(
    parameter int XW = 3,
    parameter int YW = 3,
    parameter int AW = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [XW-1:0]               node_x,
    input  logic [YW-1:0]               node_y,
    input  logic [NLINK-1:0]            lnk_vld,
    input  logic [NLINK-1:0][AW-1:0]    lnk_age,
    input  logic [NLINK-1:0][XW-1:0]    lnk_dx,
    input  logic [NLINK-1:0][YW-1:0]    lnk_dy,
    input  logic                        inj_req,
    input  logic [AW-1:0]               inj_age,
    input  logic [XW-1:0]               inj_dx,
    input  logic [YW-1:0]               inj_dy,
    output logic                        inj_ack,
    output logic [NPORT-1:0]            out_vld,
    output logic [NPORT-1:0][AW-1:0]    out_age,
    output logic [NPORT-1:0][XW-1:0]    out_dx,
    output logic [NPORT-1:0][YW-1:0]    out_dy
);
    localparam int NC = NPORT;
    localparam int RW = $clog2(NC);
    localparam int SW = $clog2(NC);

    typedef struct packed {
        logic [NPORT-1:0]         vld;
        logic [NPORT-1:0][AW-1:0] age;
        logic [NPORT-1:0][XW-1:0] dx;
        logic [NPORT-1:0][YW-1:0] dy;
    } out_state_t;

    out_state_t st_d, st_q;

    logic [NC-1:0]          cand_vld;
    logic [NC-1:0][AW-1:0]  cand_age;
    logic [NC-1:0][XW-1:0]  cand_dx;
    logic [NC-1:0][YW-1:0]  cand_dy;
    logic [NC-1:0][RW-1:0]  cand_rank;
    logic [NC-1:0]          cand_home;
    logic [NC-1:0]          cand_xok;
    logic [NC-1:0]          cand_yok;
    port_idx_t [NC-1:0]     cand_xport;
    port_idx_t [NC-1:0]     cand_yport;
    logic [NPORT-1:0]          port_busy;
    logic [NPORT-1:0][SW-1:0]  port_src;

    always_comb begin
        inj_ack  = inj_req && !(&lnk_vld);
        cand_vld = {inj_ack, lnk_vld};
        for (int i = 0; i < NLINK; i++) begin
            cand_age[i] = lnk_age[i];
            cand_dx[i]  = lnk_dx[i];
            cand_dy[i]  = lnk_dy[i];
        end
        cand_age[NLINK] = inj_age;
        cand_dx[NLINK]  = inj_dx;
        cand_dy[NLINK]  = inj_dy;
    end

    dfl_age_rank #(.N(NC), .AW(AW)) u_rank (
        .vld  (cand_vld),
        .age  (cand_age),
        .rank (cand_rank)
    );

    generate
        for (genvar gc = 0; gc < NC; gc++) begin : g_route
            dfl_route_pref #(.XW(XW), .YW(YW)) u_route (
                .node_x  (node_x),
                .node_y  (node_y),
                .dst_x   (cand_dx[gc]),
                .dst_y   (cand_dy[gc]),
                .at_home (cand_home[gc]),
                .x_ok    (cand_xok[gc]),
                .x_port  (cand_xport[gc]),
                .y_ok    (cand_yok[gc]),
                .y_port  (cand_yport[gc])
            );
        end
    endgenerate

    dfl_port_assign #(.N(NC)) u_assign (
        .clk       (clk),
        .rst_n     (rst_n),
        .vld       (cand_vld),
        .rank      (cand_rank),
        .at_home   (cand_home),
        .x_ok      (cand_xok),
        .x_port    (cand_xport),
        .y_ok      (cand_yok),
        .y_port    (cand_yport),
        .port_busy (port_busy),
        .port_src  (port_src)
    );

    always_comb begin
        st_d = '0;
        for (int p = 0; p < NPORT; p++) begin
            st_d.vld[p] = port_busy[p];
            if (port_busy[p]) begin
                st_d.age[p] = cand_age[port_src[p]];
                st_d.dx[p]  = cand_dx[port_src[p]];
                st_d.dy[p]  = cand_dy[port_src[p]];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld = st_q.vld;
    assign out_age = st_q.age;
    assign out_dx  = st_q.dx;
    assign out_dy  = st_q.dy;

    AST_CONSERVE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($countones(out_vld) == $past($countones(cand_vld))))
        else $error("flit count not conserved"); // R1
    AST_EJECT_AT_NODE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && out_vld[PORT_L]) |->
        (out_dx[PORT_L] == $past(node_x) && out_dy[PORT_L] == $past(node_y)))
        else $error("ejected flit not addressed here"); // R7
    AST_INJ_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(inj_ack)) |-> ($countones(out_vld) >= 2 ||
        $past(lnk_vld) == '0)) else $error("admitted injection lost"); // R3
endmodule

// File: tb/dfl_switch_alloc_tb.sv
module dfl_switch_alloc_tb;
    localparam int CLK_PERIOD = 10;
    localparam int XW = 3;
    localparam int YW = 3;
    localparam int AW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [XW-1:0] node_x = '0;
    logic [YW-1:0] node_y = '0;
    logic [3:0] lnk_vld = '0;
    logic [3:0][AW-1:0] lnk_age = '0;
    logic [3:0][XW-1:0] lnk_dx = '0;
    logic [3:0][YW-1:0] lnk_dy = '0;
    logic inj_req = 1'b0;
    logic [AW-1:0] inj_age = '0;
    logic [XW-1:0] inj_dx = '0;
    logic [YW-1:0] inj_dy = '0;
    logic inj_ack;
    logic [4:0] out_vld;
    logic [4:0][AW-1:0] out_age;
    logic [4:0][XW-1:0] out_dx;
    logic [4:0][YW-1:0] out_dy;

    always #(CLK_PERIOD/2) clk = ~clk;

    dfl_switch_alloc #(.XW(XW), .YW(YW), .AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .node_x(node_x), .node_y(node_y),
        .lnk_vld(lnk_vld), .lnk_age(lnk_age), .lnk_dx(lnk_dx), .lnk_dy(lnk_dy),
        .inj_req(inj_req), .inj_age(inj_age), .inj_dx(inj_dx), .inj_dy(inj_dy),
        .inj_ack(inj_ack), .out_vld(out_vld), .out_age(out_age),
        .out_dx(out_dx), .out_dy(out_dy)
    );

    int checks = 0;
    int fails = 0;
    int f_vld[5], f_age[5], f_dx[5], f_dy[5];
    int e_vld[5], e_age[5], e_dx[5], e_dy[5];
    int nx, ny;
    string e_tag;
    bit done_flag = 0;

    task automatic check_int(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Behavioural model: seniority queue, then port choice per flit.
    task automatic model();
        int acc[5];
        int used[5];
        int served[5];
        int nlnk = 0;
        for (int i = 0; i < 4; i++) nlnk += f_vld[i];
        for (int i = 0; i < 4; i++) acc[i] = f_vld[i];
        acc[4] = (f_vld[4] != 0 && nlnk < 4) ? 1 : 0;
        for (int p = 0; p < 5; p++) begin
            used[p] = 0; served[p] = 0;
            e_vld[p] = 0; e_age[p] = 0; e_dx[p] = 0; e_dy[p] = 0;
        end
        for (int k = 0; k < 5; k++) begin
            int best = -1;
            for (int i = 0; i < 5; i++)
                if (acc[i] != 0 && served[i] == 0 && (best < 0 || f_age[i] > f_age[best]))
                    best = i;
            if (best >= 0) begin
                int pt = -1;
                served[best] = 1;
                if (f_dx[best] == nx && f_dy[best] == ny && used[4] == 0) pt = 4;
                else if (f_dx[best] > nx && used[1] == 0) pt = 1;
                else if (f_dx[best] < nx && used[3] == 0) pt = 3;
                else if (f_dy[best] > ny && used[0] == 0) pt = 0;
                else if (f_dy[best] < ny && used[2] == 0) pt = 2;
                for (int p = 0; p < 4; p++)
                    if (pt < 0 && used[p] == 0) pt = p;
                used[pt] = 1;
                e_vld[pt] = 1; e_age[pt] = f_age[best];
                e_dx[pt] = f_dx[best]; e_dy[pt] = f_dy[best];
            end
        end
    endtask

    task automatic compare();
        for (int p = 0; p < 5; p++) begin
            check_int(e_tag, $sformatf("port%0d vld", p), int'(out_vld[p]), e_vld[p]);
            if (e_vld[p] != 0 && out_vld[p]) begin
                check_int(e_tag, $sformatf("port%0d age", p), int'(out_age[p]), e_age[p]);
                check_int(e_tag, $sformatf("port%0d dx", p), int'(out_dx[p]), e_dx[p]);
                check_int(e_tag, $sformatf("port%0d dy", p), int'(out_dy[p]), e_dy[p]);
            end
        end
    endtask

    // Drive at negedge; result checked at the following negedge.
    task automatic step(string tag);
        int nlnk = 0;
        @(negedge clk);
        compare();
        node_x = XW'(nx); node_y = YW'(ny);
        for (int i = 0; i < 4; i++) begin
            lnk_vld[i] = (f_vld[i] != 0);
            lnk_age[i] = AW'(f_age[i]);
            lnk_dx[i]  = XW'(f_dx[i]);
            lnk_dy[i]  = YW'(f_dy[i]);
            nlnk += f_vld[i];
        end
        inj_req = (f_vld[4] != 0);
        inj_age = AW'(f_age[4]); inj_dx = XW'(f_dx[4]); inj_dy = YW'(f_dy[4]);
        #1;
        check_int({"R3 ", tag}, "inj_ack", int'(inj_ack), (f_vld[4] != 0 && nlnk < 4) ? 1 : 0);
        e_tag = tag;
        model();
    endtask

    task automatic set_flit(int i, int v, int a, int x, int y);
        f_vld[i] = v; f_age[i] = a; f_dx[i] = x; f_dy[i] = y;
    endtask

    task automatic clear_all();
        for (int i = 0; i < 5; i++) set_flit(i, 0, 0, 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done_flag) begin
            fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        nx = 3; ny = 4;
        clear_all();
        for (int p = 0; p < 5; p++) begin
            e_vld[p] = 0; e_age[p] = 0; e_dx[p] = 0; e_dy[p] = 0;
        end
        e_tag = "R2 reset";
        repeat (3) @(negedge clk);
        check_int("R2", "out_vld in reset", int'(out_vld), 0);
        rst_n = 1'b1;

        // R6: one flit heading north-east takes east.
        clear_all(); set_flit(0, 1, 7, 5, 6);
        step("R6 xy-order");
        // R7 R8: two arrived flits; older ejects, younger deflected to port 0.
        clear_all(); set_flit(1, 1, 5, 3, 4); set_flit(2, 1, 9, 3, 4);
        step("R7 R8 double-eject");
        // R4: equal ages both want east; index 0 wins.
        clear_all(); set_flit(0, 1, 4, 7, 4); set_flit(3, 1, 4, 6, 4);
        step("R4 tie-break");
        // R3 R5 R8: all links busy, all eastbound, injection refused.
        clear_all();
        for (int i = 0; i < 4; i++) set_flit(i, 1, 10 + i, 6, 4);
        set_flit(4, 1, 63, 0, 0);
        step("R3 R5 R8 full");
        // R3 R9: three links busy, injection admitted; eject stays idle.
        clear_all();
        set_flit(0, 1, 2, 0, 4); set_flit(1, 1, 3, 3, 0); set_flit(2, 1, 1, 1, 1);
        set_flit(4, 1, 5, 3, 7);
        step("R3 R9 inject");
        // R4: injection older than links is served first.
        clear_all(); set_flit(2, 1, 3, 3, 7); set_flit(4, 1, 40, 3, 6);
        step("R4 senior-inject");
        // R2: idle cycle empties outputs.
        clear_all();
        step("R2 idle");

        for (int n = 0; n < 3000; n++) begin
            int tie = (n % 3 == 0);
            if (n % 50 == 0) begin nx = $urandom % 8; ny = $urandom % 8; end
            for (int i = 0; i < 5; i++) begin
                int home = ($urandom % 4 == 0);
                set_flit(i, ($urandom % 4 != 0) ? 1 : 0,
                         tie ? int'($urandom % 3) : int'($urandom % 64),
                         home ? nx : int'($urandom % 8),
                         home ? ny : int'($urandom % 8));
            end
            step("R1 R4 R5 R6 R7 R8 R9 random");
        end
        clear_all();
        step("R2 drain");
        @(negedge clk);
        compare();

        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule